// File: doc/BRIEF.md
# Floating-Point Fraction Rounding Unit

This block takes a wide, already normalised fraction and rounds it to either single or double precision. The fraction is 64 bits wide. Its most significant position is called index 0, and that index sits on vector bit 63. So MSB-first index `k` is vector bit `63-k`.

The rounding mode is 2 bits wide. From the fraction the block pulls out the last kept bit, the guard bit, the round bit and a sticky OR of everything below them. It then decides whether to add one to the kept field. A carry out of the kept field is pushed into the biased exponent.

Alongside the result the block reports three flags:
- whether the fraction was rounded up;
- whether the result is inexact;
- a running inexact flag, made by ORing the incoming running flag with the new inexact flag.

A parameter selects between two versions. One is a purely combinational path. The other, the default, registers the result with a one-cycle valid handshake. Normalisation, exponent overflow, denormals and special values are the job of neighbouring logic.

Top module: `fp_frac_round`

## Requirements
- R1: With `in_dbl`=0 the kept field is MSB-first indices 0..23 (vector bits 63..40). Index 23 (bit 40) is the last kept bit, index 24 (bit 39) is guard, index 25 (bit 38) is round, and sticky is the OR of indices 26..63 (bits 37..0).
- R2: With `in_dbl`=1 the kept field is indices 0..52 (vector bits 63..11). Index 52 (bit 11) is the last kept bit, index 53 (bit 10) is guard, index 54 (bit 9) is round, and sticky is the OR of indices 55..63 (bits 8..0).
- R3: Mode 2'b00 (nearest, ties to even) adds one when guard is 1 and at least one of these is 1: the last kept bit, round, or sticky.
- R4: Mode 2'b01 (toward zero) never adds one.
- R5: Mode 2'b10 (toward +infinity) adds one exactly when the sign is 0 and guard, round or sticky is 1.
- R6: Mode 2'b11 (toward -infinity) adds one exactly when the sign is 1 and guard, round or sticky is 1.
- R7: When adding one overflows the kept field, the kept field becomes a leading 1 followed by zeros and `out_exp` equals `in_exp`+1. Otherwise `out_exp` equals `in_exp`.
- R8: Every vector bit below the kept field is 0 in `out_frac`.
- R9: `out_up` equals the add-one decision. `out_inexact` is guard OR round OR sticky.
- R10: `out_sticky` is `in_sticky_prev` OR `out_inexact`.
- R11: In the registered version, `out_valid` and the result appear one cycle after `in_valid`. Result registers load only while `in_valid` is 1. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand valid |
| in_dbl | input | 1 | 1 selects double precision, 0 selects single |
| in_sign | input | 1 | Sign of the operand |
| in_mode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| in_exp | input | EXP_W | Biased exponent |
| in_frac | input | FRAC_W | Fraction, MSB-first index 0 on the top vector bit |
| in_sticky_prev | input | 1 | Running inexact flag before this operation |
| out_valid | output | 1 | Result valid |
| out_frac | output | FRAC_W | Rounded fraction with lower bits cleared |
| out_exp | output | EXP_W | Exponent after carry |
| out_up | output | 1 | Fraction was rounded up |
| out_inexact | output | 1 | Dropped bits were nonzero |
| out_sticky | output | 1 | Updated running inexact flag |

## Verification
In the default registered version every result and all three flags arrive together, exactly one clock after the operand is presented with `in_valid` high. The bench drives each operand on a falling edge. It samples the outputs on the following falling edge, which lies after the single capturing rising edge, so it never reads mid-update. Operands are streamed back to back, so each sample also proves that the previous operand has been replaced. One extra cycle with `in_valid` low checks that `out_valid` drops while the fraction holds.

// File: rtl/fp_frac_round_pkg.sv
package fp_frac_round_pkg;

   typedef enum logic [1:0] {
      RND_NEAR_EVEN = 2'b00,
      RND_TO_ZERO   = 2'b01,
      RND_POS_INF   = 2'b10,
      RND_NEG_INF   = 2'b11
   } rnd_mode_e;

   // Bits around the rounding point of one precision
   typedef struct packed {
      logic last;   // last kept bit
      logic guard;  // first dropped bit
      logic rbit;   // second dropped bit
      logic stk;    // OR of all remaining dropped bits
   } rnd_taps_t;

endpackage

// File: rtl/fp_frac_round_taps.sv
module fp_frac_round_taps
   import fp_frac_round_pkg::*;
#(
   parameter int FRAC_W = 64,
   parameter int KEEP   = 24
) (
   input  logic [FRAC_W-1:0] frac,
   output rnd_taps_t         taps
);

   localparam int LAST_POS  = FRAC_W - KEEP;
   localparam int GUARD_POS = LAST_POS - 1;
   localparam int RBIT_POS  = LAST_POS - 2;
   localparam int STK_TOP   = LAST_POS - 3;

   if (STK_TOP < 0) begin : g_bad_keep
      $error("fp_frac_round_taps: KEEP leaves no room for guard, round and sticky");
   end

   always_comb begin
      taps.last  = frac[LAST_POS];
      taps.guard = frac[GUARD_POS];
      taps.rbit  = frac[RBIT_POS];
      taps.stk   = |frac[STK_TOP:0];
   end

endmodule

// File: rtl/fp_frac_round_decide.sv
module fp_frac_round_decide
   import fp_frac_round_pkg::*;
(
   input  rnd_mode_e mode,
   input  logic      sign,
   input  rnd_taps_t taps,
   output logic      inc,
   output logic      inexact
);

   logic dropped_any;

   always_comb begin
      dropped_any = taps.guard | taps.rbit | taps.stk;
      unique case (mode)
         RND_NEAR_EVEN: inc = taps.guard & (taps.last | taps.rbit | taps.stk);
         RND_TO_ZERO:   inc = 1'b0;
         RND_POS_INF:   inc = ~sign & dropped_any;
         RND_NEG_INF:   inc =  sign & dropped_any;
         default:       inc = 1'b0;
      endcase
      inexact = dropped_any;
   end

endmodule

// File: rtl/fp_frac_round_incr.sv
module fp_frac_round_incr #(
   parameter int FRAC_W = 64,
   parameter int EXP_W  = 11,
   parameter int KEEP   = 24
) (
   input  logic [FRAC_W-1:0] frac,
   input  logic [EXP_W-1:0]  exp_in,
   input  logic              inc,
   output logic [FRAC_W-1:0] frac_out,
   output logic [EXP_W-1:0]  exp_out
);

   localparam int DROP_W = FRAC_W - KEEP;

   logic [KEEP:0]   sum;
   logic [KEEP-1:0] kept;
   logic            carry;

   always_comb begin
      sum   = {1'b0, frac[FRAC_W-1 -: KEEP]} + {{KEEP{1'b0}}, inc};
      carry = sum[KEEP];
      // On overflow the kept field is all zeros: restore the leading one
      kept  = carry ? {1'b1, {(KEEP-1){1'b0}}} : sum[KEEP-1:0];
      frac_out = {kept, {DROP_W{1'b0}}};
      exp_out  = exp_in + {{(EXP_W-1){1'b0}}, carry};
   end

endmodule

// File: rtl/fp_frac_round.sv
module fp_frac_round
   import fp_frac_round_pkg::*;
#(
   parameter int FRAC_W     = 64,
   parameter int EXP_W      = 11,
   parameter int SP_KEEP    = 24,
   parameter int DP_KEEP    = 53,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_dbl,
   input  logic              in_sign,
   input  logic [1:0]        in_mode,
   input  logic [EXP_W-1:0]  in_exp,
   input  logic [FRAC_W-1:0] in_frac,
   input  logic              in_sticky_prev,
   output logic              out_valid,
   output logic [FRAC_W-1:0] out_frac,
   output logic [EXP_W-1:0]  out_exp,
   output logic              out_up,
   output logic              out_inexact,
   output logic              out_sticky
);

   localparam int N_PREC = 2;

   if (SP_KEEP >= DP_KEEP) begin : g_bad_order
      $error("fp_frac_round: SP_KEEP must be narrower than DP_KEEP");
   end
   if (DP_KEEP + 3 > FRAC_W) begin : g_bad_width
      $error("fp_frac_round: FRAC_W too narrow for DP_KEEP plus three tap bits");
   end
   if (EXP_W < 2) begin : g_bad_exp
      $error("fp_frac_round: EXP_W must be at least 2");
   end

   rnd_mode_e mode;
   assign mode = rnd_mode_e'(in_mode);

   logic [FRAC_W-1:0] lane_frac [N_PREC];
   logic [EXP_W-1:0]  lane_exp  [N_PREC];
   logic              lane_inc  [N_PREC];
   logic              lane_inx  [N_PREC];

   // Lane 0 rounds to single precision, lane 1 to double
   for (genvar p = 0; p < N_PREC; p++) begin : g_lane
      localparam int KEEP = (p == 0) ? SP_KEEP : DP_KEEP;
      rnd_taps_t taps;

      fp_frac_round_taps #(.FRAC_W(FRAC_W), .KEEP(KEEP)) u_taps (
         .frac (in_frac),
         .taps (taps)
      );

      fp_frac_round_decide u_decide (
         .mode    (mode),
         .sign    (in_sign),
         .taps    (taps),
         .inc     (lane_inc[p]),
         .inexact (lane_inx[p])
      );

      fp_frac_round_incr #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .KEEP(KEEP)) u_incr (
         .frac     (in_frac),
         .exp_in   (in_exp),
         .inc      (lane_inc[p]),
         .frac_out (lane_frac[p]),
         .exp_out  (lane_exp[p])
      );
   end

   logic [FRAC_W-1:0] res_frac;
   logic [EXP_W-1:0]  res_exp;
   logic              res_up;
   logic              res_inx;
   logic              res_stk;

   always_comb begin
      res_frac = lane_frac[in_dbl];
      res_exp  = lane_exp[in_dbl];
      res_up   = lane_inc[in_dbl];
      res_inx  = lane_inx[in_dbl];
      res_stk  = in_sticky_prev | res_inx;
   end

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid   <= 1'b0;
            out_frac    <= '0;
            out_exp     <= '0;
            out_up      <= 1'b0;
            out_inexact <= 1'b0;
            out_sticky  <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_frac    <= res_frac;
               out_exp     <= res_exp;
               out_up      <= res_up;
               out_inexact <= res_inx;
               out_sticky  <= res_stk;
            end
         end
      end
   end else begin : g_comb
      always_comb begin
         out_valid   = in_valid;
         out_frac    = res_frac;
         out_exp     = res_exp;
         out_up      = res_up;
         out_inexact = res_inx;
         out_sticky  = res_stk;
      end
   end

endmodule

// File: rtl/fp_frac_round_chk.sv
module fp_frac_round_chk #(
   parameter int FRAC_W     = 64,
   parameter int EXP_W      = 11,
   parameter int SP_KEEP    = 24,
   parameter int DP_KEEP    = 53,
   parameter bit REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_dbl,
   input logic              in_sign,
   input logic [1:0]        in_mode,
   input logic [EXP_W-1:0]  in_exp,
   input logic              in_sticky_prev,
   input logic              out_valid,
   input logic [FRAC_W-1:0] out_frac,
   input logic [EXP_W-1:0]  out_exp,
   input logic              out_up,
   input logic              out_inexact,
   input logic              out_sticky
);

   if (REGISTERED) begin : g_seq
      assert_valid_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      assert_valid_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      assert_sticky_accum_R10: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (out_sticky == ($past(in_sticky_prev) | out_inexact)));
      assert_up_implies_inexact_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && out_up) |-> out_inexact);
      assert_rtz_never_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && $past(in_mode) == 2'b01) |-> !out_up);
      assert_pos_inf_neg_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && $past(in_mode) == 2'b10 && $past(in_sign)) |-> !out_up);
      assert_neg_inf_pos_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && $past(in_mode) == 2'b11 && !$past(in_sign)) |-> !out_up);
      assert_sp_low_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !$past(in_dbl)) |-> (out_frac[FRAC_W-SP_KEEP-1:0] == '0));
      assert_dp_low_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && $past(in_dbl)) |-> (out_frac[FRAC_W-DP_KEEP-1:0] == '0));
      assert_exp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !out_up) |-> (out_exp == $past(in_exp)));
      assert_carry_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && out_exp != $past(in_exp)) |-> (out_up && out_frac[FRAC_W-1]));
   end else begin : g_cmb
      assert_rtz_never_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_mode == 2'b01) |-> !out_up);
      assert_sticky_accum_R10: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |-> (out_sticky == (in_sticky_prev | out_inexact)));
      assert_up_implies_inexact_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && out_up) |-> out_inexact);
      assert_sp_low_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !in_dbl) |-> (out_frac[FRAC_W-SP_KEEP-1:0] == '0));
   end

endmodule

bind fp_frac_round fp_frac_round_chk #(
   .FRAC_W     (FRAC_W),
   .EXP_W      (EXP_W),
   .SP_KEEP    (SP_KEEP),
   .DP_KEEP    (DP_KEEP),
   .REGISTERED (REGISTERED)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .in_valid       (in_valid),
   .in_dbl         (in_dbl),
   .in_sign        (in_sign),
   .in_mode        (in_mode),
   .in_exp         (in_exp),
   .in_sticky_prev (in_sticky_prev),
   .out_valid      (out_valid),
   .out_frac       (out_frac),
   .out_exp        (out_exp),
   .out_up         (out_up),
   .out_inexact    (out_inexact),
   .out_sticky     (out_sticky)
);

// File: tb/fp_frac_round_tb.sv
module fp_frac_round_tb;

   localparam int CLK_PERIOD = 10;
   localparam int FRAC_W     = 64;
   localparam int EXP_W      = 11;
   localparam int N_VEC      = 21;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_dbl = 1'b0;
   logic              in_sign = 1'b0;
   logic [1:0]        in_mode = 2'b00;
   logic [EXP_W-1:0]  in_exp = '0;
   logic [FRAC_W-1:0] in_frac = '0;
   logic              in_sticky_prev = 1'b0;
   logic              out_valid;
   logic [FRAC_W-1:0] out_frac;
   logic [EXP_W-1:0]  out_exp;
   logic              out_up;
   logic              out_inexact;
   logic              out_sticky;

   always #(CLK_PERIOD/2) clk = ~clk;

   fp_frac_round u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .in_valid       (in_valid),
      .in_dbl         (in_dbl),
      .in_sign        (in_sign),
      .in_mode        (in_mode),
      .in_exp         (in_exp),
      .in_frac        (in_frac),
      .in_sticky_prev (in_sticky_prev),
      .out_valid      (out_valid),
      .out_frac       (out_frac),
      .out_exp        (out_exp),
      .out_up         (out_up),
      .out_inexact    (out_inexact),
      .out_sticky     (out_sticky)
   );

   // {dbl, sign, mode, sticky_in, exp, frac, expected up, expected inexact}
   localparam logic [81:0] VEC [N_VEC] = '{
      {1'b0,1'b0,2'b00,1'b0,11'h400,64'h8000_0080_0000_0000,1'b0,1'b1},
      {1'b0,1'b0,2'b00,1'b0,11'h400,64'h8000_0180_0000_0000,1'b1,1'b1},
      {1'b0,1'b0,2'b00,1'b0,11'h400,64'h8000_00C0_0000_0000,1'b1,1'b1},
      {1'b0,1'b0,2'b00,1'b0,11'h400,64'h8000_0040_0000_0001,1'b0,1'b1},
      {1'b0,1'b0,2'b00,1'b0,11'h400,64'h8000_0100_0000_0000,1'b0,1'b0},
      {1'b0,1'b0,2'b01,1'b0,11'h400,64'h8000_00FF_FFFF_FFFF,1'b0,1'b1},
      {1'b0,1'b0,2'b10,1'b0,11'h400,64'h8000_0000_0000_0001,1'b1,1'b1},
      {1'b0,1'b1,2'b10,1'b0,11'h400,64'h8000_0000_0000_0001,1'b0,1'b1},
      {1'b0,1'b1,2'b11,1'b0,11'h400,64'h8000_0040_0000_0000,1'b1,1'b1},
      {1'b0,1'b0,2'b11,1'b0,11'h400,64'h8000_0040_0000_0000,1'b0,1'b1},
      {1'b0,1'b0,2'b00,1'b0,11'h7FE,64'hFFFF_FF80_0000_0000,1'b1,1'b1},
      {1'b1,1'b0,2'b00,1'b0,11'h3FF,64'h8000_0000_0000_0400,1'b0,1'b1},
      {1'b1,1'b0,2'b00,1'b0,11'h3FF,64'h8000_0000_0000_0C00,1'b1,1'b1},
      {1'b1,1'b0,2'b10,1'b0,11'h3FF,64'h8000_0000_0000_0100,1'b1,1'b1},
      {1'b1,1'b0,2'b00,1'b0,11'h3FF,64'h8000_0000_0000_0500,1'b1,1'b1},
      {1'b1,1'b0,2'b00,1'b0,11'h123,64'hFFFF_FFFF_FFFF_FC00,1'b1,1'b1},
      {1'b0,1'b0,2'b00,1'b0,11'h400,64'h8000_0000_0000_0800,1'b0,1'b1},
      {1'b1,1'b0,2'b00,1'b0,11'h400,64'h8000_0000_0000_0800,1'b0,1'b0},
      {1'b1,1'b0,2'b01,1'b1,11'h200,64'h8000_0000_0000_0000,1'b0,1'b0},
      {1'b0,1'b1,2'b01,1'b0,11'h200,64'h8000_0080_0000_0000,1'b0,1'b1},
      {1'b1,1'b1,2'b11,1'b1,11'h200,64'h8000_0000_0000_0400,1'b1,1'b1}
   };

   localparam string VREQ [N_VEC] = '{
      "R3", "R3", "R3", "R1", "R1", "R4", "R5", "R5", "R6", "R6", "R7",
      "R3", "R3", "R2", "R2", "R7", "R1", "R2", "R10", "R9", "R6"
   };

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   // Reference model written from the requirements
   task automatic ref_round(input logic dbl, input logic sign, input logic [1:0] mode,
                            input logic [EXP_W-1:0] e, input logic [63:0] f,
                            output logic [63:0] rf, output logic [EXP_W-1:0] re,
                            output logic up, output logic inx);
      int keep;
      logic lsb, g, r, s;
      logic [64:0] kept;
      keep = dbl ? 53 : 24;
      lsb  = f[64-keep];
      g    = f[63-keep];
      r    = f[62-keep];
      s    = (f & ((64'd1 << (62-keep)) - 64'd1)) != 64'd0;
      inx  = g | r | s;
      case (mode)
         2'b00:   up = (lsb & g) | (!lsb & g & r) | (!lsb & g & s);
         2'b10:   up = !sign && inx;
         2'b11:   up = sign && inx;
         default: up = 1'b0;
      endcase
      kept = {1'b0, f >> (64-keep)} + 65'(up);
      if ((kept >> keep) != 65'd0) begin
         rf = 64'd1 << 63;
         re = e + 1'b1;
      end else begin
         rf = kept[63:0] << (64-keep);
         re = e;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0]      ef;
      logic [EXP_W-1:0] ee;
      logic             eu, ei;
      logic [63:0]      last_frac;

      last_frac = '0;

      // Reset state (R11)
      in_valid = 1'b1;
      in_frac  = 64'hFFFF_FFFF_FFFF_FFFF;
      repeat (3) @(negedge clk);
      chk("R11 reset valid", 64'(out_valid), 64'd0);
      chk("R11 reset frac",  out_frac, 64'd0);
      chk("R11 reset flags", {61'd0, out_up, out_inexact, out_sticky}, 64'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // Vector table, streamed back to back
      for (int i = 0; i < N_VEC; i++) begin
         logic [81:0] v;
         v = VEC[i];
         in_valid       = 1'b1;
         in_dbl         = v[81];
         in_sign        = v[80];
         in_mode        = v[79:78];
         in_sticky_prev = v[77];
         in_exp         = v[76:66];
         in_frac        = v[65:2];
         ref_round(v[81], v[80], v[79:78], v[76:66], v[65:2], ef, ee, eu, ei);
         @(negedge clk);
         chk({VREQ[i], " R11 valid"},     64'(out_valid), 64'd1);
         chk({VREQ[i], " R8 frac"},       out_frac, ef);
         chk({VREQ[i], " R7 exp"},        64'(out_exp), 64'(ee));
         chk({VREQ[i], " R9 up table"},   64'(out_up), 64'(v[1]));
         chk({VREQ[i], " R9 up model"},   64'(out_up), 64'(eu));
         chk({VREQ[i], " R9 inexact"},    64'(out_inexact), 64'(v[0]));
         chk({VREQ[i], " R10 sticky"},    64'(out_sticky), 64'(v[77] | ei));
         last_frac = ef;
      end

      // Directed: carry in single precision gives leading one and exp+1 (R7)
      in_dbl = 1'b0; in_sign = 1'b0; in_mode = 2'b10; in_sticky_prev = 1'b0;
      in_exp = 11'h010; in_frac = 64'hFFFF_FF00_0000_0001;
      @(negedge clk);
      chk("R7 carry frac", out_frac, 64'h8000_0000_0000_0000);
      chk("R7 carry exp",  64'(out_exp), 64'h011);
      last_frac = 64'h8000_0000_0000_0000;

      // Directed: in_valid low leaves result registers untouched (R11)
      in_valid = 1'b0;
      in_frac  = 64'h1234_5678_9ABC_DEF0;
      in_exp   = 11'h055;
      @(negedge clk);
      chk("R11 valid low", 64'(out_valid), 64'd0);
      chk("R11 frac hold", out_frac, last_frac);
      chk("R11 exp hold",  64'(out_exp), 64'h011);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule